// File: doc/BRIEF.md
# Machine-Mode Control Register File

This block holds the machine-level control and status registers of a small 32-bit embedded core and carries out the register-access instructions for them. A decoded request carries a 12-bit register address, an operation code, a source operand and a flag from the decoder that says whether the instruction means to write. The block answers with the value the register held before the access. It also flags an illegal-instruction fault and gives the matching cause code. The trap status, trap vector and trap value registers live here, with the identification constants. Every write passes through a legalisation step, so fields that the profile hardwires keep their fixed values.

Requests enter on a valid/ready channel and answers leave on a second valid/ready channel, one answer per request, in order. A request is taken in the cycle where `req_valid` and `req_ready` are both high, and `req_ready` is high whenever the answer register is empty or is being drained in that cycle. The answer appears in the cycle after the request is taken. It stays stable until `rsp_ready` is seen high.

Addresses that this block does not implement can be claimed by a neighbouring counter bank through a decode hook. The neighbour raises `ext_claim` and supplies its read value on `ext_rdata`. The block computes the combined write value and strobes `ext_we` when such an access is legal and means to write.

Top module: `csr_mfile`

## Requirements
- R1: After reset the trap value register reads 0, the status register reads 0x0000_1800 (both interrupt-enable bits 0), and the trap vector reads the `TVEC_RESET` parameter with its two low bits forced to 0.
- R2: `req_ready` is high exactly when `rsp_valid` is low or `rsp_ready` is high. While `rsp_valid` is high and `rsp_ready` is low, the answer outputs hold their values.
- R3: A legal answer's `rsp_rdata` is the register value before the access. An illegal answer's `rsp_rdata` is 0.
- R4: Operation codes: 1 write, 2 set (OR), 3 clear (AND-NOT); 5, 6 and 7 are the same operations using only `req_src[4:0]`, zero-extended. Codes 0 and 4 are illegal.
- R5: The trap value register at 0x343 keeps all 32 bits of every write, set and clear.
- R6: In the trap vector at 0x305, bits [31:2] are writable and bits [1:0] always read 0, whatever value is written.
- R7: In the status register at 0x300, bits [12:11] always read 3. Only bit 3 and bit 7 are writable, and every other bit reads 0.
- R8: Addresses 0xF11, 0xF12, 0xF13 and 0xF14 read the constants `VENDOR_ID`, `ARCH_ID`, `IMPL_ID` and `HART_ID`.
- R9: A request with `req_wen`=1 to an address whose bits [11:10] are 2'b11 is illegal. The same address read with `req_wen`=0 is legal.
- R10: An address that is neither local nor claimed by `ext_claim` is illegal; this covers 0xC00, 0xC02, 0xC80 and 0xC82. An illegal answer has `rsp_cause`=2, and a legal one has 0.
- R11: An illegal request changes no register.
- R12: With `req_wen`=0 no register is written, whatever the operation and source.
- R13: A claimed address returns `ext_rdata`. A legal claimed access with `req_wen`=1 raises `ext_we` in its accept cycle, with `ext_wdata` set to the combined value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_addr | input | 12 | Register address |
| req_op | input | 3 | Operation code |
| req_src | input | 32 | Source operand (low 5 bits for immediate forms) |
| req_wen | input | 1 | Decoder's write intent |
| ext_claim | input | 1 | Neighbour implements `req_addr` |
| ext_rdata | input | 32 | Neighbour's value at `req_addr` |
| ext_we | output | 1 | Write strobe to the neighbour |
| ext_wdata | output | 32 | Write value to the neighbour |
| rsp_valid | output | 1 | Answer present |
| rsp_ready | input | 1 | Answer can be taken |
| rsp_rdata | output | 32 | Old register value |
| rsp_illegal | output | 1 | Illegal-instruction fault |
| rsp_cause | output | 4 | Fault cause code |

## Verification
A wrong stored bit stays hidden until the next read of that register. That read returns it in the cycle after it is taken. For this reason every write in the sequence is followed at some point by a read of the same register, and each trap is followed by a read that must show the value from before the trap. A legalisation fault shows up as a read value with a hardwired field that is not 0 or 3. A decode or permission fault shows up at once, in the next answer, as a wrong illegal flag or cause code.

// File: rtl/csr_mfile_pkg.sv
package csr_mfile_pkg;
  localparam int XLEN     = 32;
  localparam int ADDR_W   = 12;
  localparam int OP_W     = 3;
  localparam int CAUSE_W  = 4;
  localparam int IMM_W    = 5;

  localparam logic [OP_W-1:0] OP_WR   = 3'd1;
  localparam logic [OP_W-1:0] OP_SET  = 3'd2;
  localparam logic [OP_W-1:0] OP_CLR  = 3'd3;

  localparam logic [ADDR_W-1:0] A_STATUS = 12'h300;
  localparam logic [ADDR_W-1:0] A_TVEC   = 12'h305;
  localparam logic [ADDR_W-1:0] A_TVAL   = 12'h343;
  localparam logic [ADDR_W-1:0] A_VENDOR = 12'hF11;
  localparam logic [ADDR_W-1:0] A_ARCH   = 12'hF12;
  localparam logic [ADDR_W-1:0] A_IMPL   = 12'hF13;
  localparam logic [ADDR_W-1:0] A_HART   = 12'hF14;

  localparam int ST_IE_BIT   = 3;
  localparam int ST_PIE_BIT  = 7;
  localparam int ST_PRV_LO   = 11;
  localparam int TVEC_MODE_W = 2;

  localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL = 4'd2;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_STATUS, SEL_TVEC, SEL_TVAL,
    SEL_VENDOR, SEL_ARCH, SEL_IMPL, SEL_HART, SEL_EXT
  } csr_sel_e;

  typedef struct packed {
    logic                        ie;
    logic                        pie;
    logic [XLEN-TVEC_MODE_W-1:0] tvec_base;
    logic [XLEN-1:0]             tval;
  } csr_state_t;

  function automatic logic [XLEN-1:0] csr_combine(input logic [OP_W-1:0] op,
                                                  input logic [XLEN-1:0] old_v,
                                                  input logic [XLEN-1:0] src);
    logic [XLEN-1:0] opnd;
    opnd = op[2] ? {{(XLEN-IMM_W){1'b0}}, src[IMM_W-1:0]} : src;
    case (op[1:0])
      2'b01:   return opnd;
      2'b10:   return old_v | opnd;
      2'b11:   return old_v & ~opnd;
      default: return old_v;
    endcase
  endfunction
endpackage

// File: rtl/csr_mfile_decode.sv
module csr_mfile_decode
  import csr_mfile_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              ext_claim,
  output csr_sel_e          sel
);
  always_comb begin
    case (addr)
      A_STATUS: sel = SEL_STATUS;
      A_TVEC:   sel = SEL_TVEC;
      A_TVAL:   sel = SEL_TVAL;
      A_VENDOR: sel = SEL_VENDOR;
      A_ARCH:   sel = SEL_ARCH;
      A_IMPL:   sel = SEL_IMPL;
      A_HART:   sel = SEL_HART;
      default:  sel = ext_claim ? SEL_EXT : SEL_NONE;
    endcase
  end
endmodule

// File: rtl/csr_mfile_rmux.sv
module csr_mfile_rmux
  import csr_mfile_pkg::*;
#(
  parameter logic [XLEN-1:0] VENDOR_ID = 32'h0,
  parameter logic [XLEN-1:0] ARCH_ID   = 32'h0,
  parameter logic [XLEN-1:0] IMPL_ID   = 32'h0,
  parameter logic [XLEN-1:0] HART_ID   = 32'h0
) (
  input  csr_sel_e        sel,
  input  csr_state_t      st,
  input  logic [XLEN-1:0] ext_rdata,
  output logic [XLEN-1:0] rdata
);
  always_comb begin
    rdata = '0;
    case (sel)
      SEL_STATUS: begin
        rdata[ST_PRV_LO+1:ST_PRV_LO] = 2'b11;
        rdata[ST_PIE_BIT]            = st.pie;
        rdata[ST_IE_BIT]             = st.ie;
      end
      SEL_TVEC:   rdata = {st.tvec_base, {TVEC_MODE_W{1'b0}}};
      SEL_TVAL:   rdata = st.tval;
      SEL_VENDOR: rdata = VENDOR_ID;
      SEL_ARCH:   rdata = ARCH_ID;
      SEL_IMPL:   rdata = IMPL_ID;
      SEL_HART:   rdata = HART_ID;
      SEL_EXT:    rdata = ext_rdata;
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/csr_mfile_regs.sv
module csr_mfile_regs
  import csr_mfile_pkg::*;
#(
  parameter logic [XLEN-1:0] TVEC_RESET = 32'h0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  csr_sel_e        sel,
  input  logic [XLEN-1:0] wdata,
  output csr_state_t      st
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st.ie        <= 1'b0;
      st.pie       <= 1'b0;
      st.tvec_base <= TVEC_RESET[XLEN-1:TVEC_MODE_W];
      st.tval      <= '0;
    end else if (we) begin
      case (sel)
        SEL_STATUS: begin
          st.ie  <= wdata[ST_IE_BIT];
          st.pie <= wdata[ST_PIE_BIT];
        end
        SEL_TVEC: st.tvec_base <= wdata[XLEN-1:TVEC_MODE_W];
        SEL_TVAL: st.tval      <= wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/csr_mfile.sv
module csr_mfile
  import csr_mfile_pkg::*;
#(
  parameter logic [XLEN-1:0] TVEC_RESET = 32'h0000_0100,
  parameter logic [XLEN-1:0] VENDOR_ID  = 32'h0000_0A5C,
  parameter logic [XLEN-1:0] ARCH_ID    = 32'h0000_0003,
  parameter logic [XLEN-1:0] IMPL_ID    = 32'h0000_0001,
  parameter logic [XLEN-1:0] HART_ID    = 32'h0000_0007
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [OP_W-1:0]    req_op,
  input  logic [XLEN-1:0]    req_src,
  input  logic               req_wen,
  input  logic               ext_claim,
  input  logic [XLEN-1:0]    ext_rdata,
  output logic               ext_we,
  output logic [XLEN-1:0]    ext_wdata,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [XLEN-1:0]    rsp_rdata,
  output logic               rsp_illegal,
  output logic [CAUSE_W-1:0] rsp_cause
);
  csr_sel_e        sel;
  csr_state_t      st_q;
  logic [XLEN-1:0] old_v, new_v;
  logic            accept, op_ok, ro_hit, illegal, do_wr;

  csr_mfile_decode u_dec (.addr(req_addr), .ext_claim(ext_claim), .sel(sel));

  csr_mfile_rmux #(.VENDOR_ID(VENDOR_ID), .ARCH_ID(ARCH_ID),
                   .IMPL_ID(IMPL_ID), .HART_ID(HART_ID)) u_rmux (
    .sel(sel), .st(st_q), .ext_rdata(ext_rdata), .rdata(old_v));

  assign new_v   = csr_combine(req_op, old_v, req_src);
  assign op_ok   = (req_op[1:0] != 2'b00);
  assign ro_hit  = (req_addr[ADDR_W-1:ADDR_W-2] == 2'b11);
  assign illegal = !op_ok || (sel == SEL_NONE) || (ro_hit && req_wen);

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign do_wr     = accept && !illegal && req_wen;

  csr_mfile_regs #(.TVEC_RESET(TVEC_RESET)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(do_wr), .sel(sel), .wdata(new_v), .st(st_q));

  assign ext_we    = do_wr && (sel == SEL_EXT);
  assign ext_wdata = new_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
      rsp_illegal <= 1'b0;
      rsp_cause   <= '0;
    end else if (accept) begin
      rsp_valid   <= 1'b1;
      rsp_rdata   <= illegal ? '0 : old_v;
      rsp_illegal <= illegal;
      rsp_cause   <= illegal ? CAUSE_ILLEGAL : '0;
    end else if (rsp_ready) begin
      rsp_valid   <= 1'b0;
    end
  end
endmodule

// File: rtl/csr_mfile_chk.sv
module csr_mfile_chk
  import csr_mfile_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic [ADDR_W-1:0]  req_addr,
  input logic               req_wen,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic [XLEN-1:0]    rsp_rdata,
  input logic               rsp_illegal,
  input logic [CAUSE_W-1:0] rsp_cause,
  input csr_state_t         st
);
  a_r9_ro_write_traps: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_addr[ADDR_W-1:ADDR_W-2] == 2'b11 && req_wen)
      |=> (rsp_valid && rsp_illegal));

  a_r2_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_illegal)));

  a_r10_cause_code: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_cause == (rsp_illegal ? CAUSE_ILLEGAL : 4'd0)));

  a_r11_trap_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_illegal && $past(req_valid && req_ready)) |-> (st == $past(st)));

  a_r12_no_intent_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && req_ready && !req_wen) |-> (st == $past(st)));

  a_r7_prv_field_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_illegal && $past(req_valid && req_ready && req_addr == A_STATUS))
      |-> (rsp_rdata[ST_PRV_LO+1:ST_PRV_LO] == 2'b11));
endmodule

bind csr_mfile csr_mfile_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_wen(req_wen), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_illegal(rsp_illegal),
  .rsp_cause(rsp_cause), .st(st_q));

// File: tb/csr_mfile_bench.sv
`timescale 1ns/1ps
module csr_mfile_bench;
  localparam logic [31:0] TVEC_R = 32'h0000_0100;
  localparam logic [31:0] VEND   = 32'h0000_0A5C;
  localparam logic [31:0] ARCH   = 32'h0000_0003;
  localparam logic [31:0] IMPL   = 32'h0000_0001;
  localparam logic [31:0] HART   = 32'h0000_0007;
  localparam logic [31:0] EXTV   = 32'h1234_5678;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_wen = 1'b0, rsp_ready = 1'b1;
  logic [11:0] req_addr = '0;
  logic [2:0]  req_op = '0;
  logic [31:0] req_src = '0;
  logic req_ready, ext_we, rsp_valid, rsp_illegal, ext_claim;
  logic [31:0] ext_wdata, rsp_rdata;
  logic [3:0]  rsp_cause;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  assign ext_claim = (req_addr == 12'hB00);

  csr_mfile #(.TVEC_RESET(TVEC_R), .VENDOR_ID(VEND), .ARCH_ID(ARCH),
              .IMPL_ID(IMPL), .HART_ID(HART)) u_csr_mfile (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_op(req_op), .req_src(req_src), .req_wen(req_wen),
    .ext_claim(ext_claim), .ext_rdata(EXTV), .ext_we(ext_we), .ext_wdata(ext_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_illegal(rsp_illegal), .rsp_cause(rsp_cause));

  // row: {req tag, addr, op, src, wen, expected rdata, expected illegal}
  localparam int NV = 33;
  localparam logic [88:0] VEC [NV] = '{
    {8'd1,  12'h343, 3'd2, 32'h0,         1'b0, 32'h0,         1'b0}, // R1
    {8'd1,  12'h305, 3'd2, 32'h0,         1'b0, TVEC_R,        1'b0}, // R1
    {8'd1,  12'h300, 3'd2, 32'h0,         1'b0, 32'h0000_1800, 1'b0}, // R1
    {8'd5,  12'h343, 3'd1, 32'hDEAD_BEEF, 1'b1, 32'h0,         1'b0}, // R5
    {8'd4,  12'h343, 3'd2, 32'h0000_0F00, 1'b1, 32'hDEAD_BEEF, 1'b0}, // R4 R3
    {8'd4,  12'h343, 3'd3, 32'hFFFF_0000, 1'b1, 32'hDEAD_BFEF, 1'b0}, // R4
    {8'd4,  12'h343, 3'd5, 32'hFFFF_FF15, 1'b1, 32'h0000_BFEF, 1'b0}, // R4
    {8'd4,  12'h343, 3'd6, 32'h0000_000A, 1'b1, 32'h0000_0015, 1'b0}, // R4
    {8'd4,  12'h343, 3'd7, 32'h0000_0014, 1'b1, 32'h0000_001F, 1'b0}, // R4
    {8'd12, 12'h343, 3'd2, 32'hFFFF_FFFF, 1'b0, 32'h0000_000B, 1'b0}, // R12
    {8'd12, 12'h343, 3'd1, 32'h5555_5555, 1'b0, 32'h0000_000B, 1'b0}, // R12
    {8'd6,  12'h305, 3'd1, 32'h8000_0203, 1'b1, TVEC_R,        1'b0}, // R6
    {8'd6,  12'h305, 3'd2, 32'h0,         1'b0, 32'h8000_0200, 1'b0}, // R6
    {8'd7,  12'h300, 3'd1, 32'hFFFF_FFFF, 1'b1, 32'h0000_1800, 1'b0}, // R7
    {8'd7,  12'h300, 3'd3, 32'h0000_0008, 1'b1, 32'h0000_1888, 1'b0}, // R7
    {8'd7,  12'h300, 3'd2, 32'h0,         1'b0, 32'h0000_1880, 1'b0}, // R7
    {8'd8,  12'hF11, 3'd2, 32'h0,         1'b0, VEND,          1'b0}, // R8
    {8'd8,  12'hF12, 3'd2, 32'h0,         1'b0, ARCH,          1'b0}, // R8
    {8'd8,  12'hF13, 3'd2, 32'h0,         1'b0, IMPL,          1'b0}, // R8
    {8'd8,  12'hF14, 3'd2, 32'h0,         1'b0, HART,          1'b0}, // R8
    {8'd9,  12'hF11, 3'd1, 32'h0,         1'b1, 32'h0,         1'b1}, // R9
    {8'd9,  12'hF12, 3'd6, 32'h0,         1'b0, ARCH,          1'b0}, // R9
    {8'd9,  12'hF14, 3'd6, 32'h1,         1'b1, 32'h0,         1'b1}, // R9
    {8'd10, 12'hC00, 3'd2, 32'h0,         1'b0, 32'h0,         1'b1}, // R10
    {8'd10, 12'hC02, 3'd2, 32'h0,         1'b0, 32'h0,         1'b1}, // R10
    {8'd10, 12'hC80, 3'd2, 32'h0,         1'b0, 32'h0,         1'b1}, // R10
    {8'd10, 12'hC82, 3'd2, 32'h0,         1'b0, 32'h0,         1'b1}, // R10
    {8'd10, 12'h7B0, 3'd1, 32'h1,         1'b1, 32'h0,         1'b1}, // R10
    {8'd11, 12'h343, 3'd0, 32'h0000_AAAA, 1'b1, 32'h0,         1'b1}, // R11 R4
    {8'd11, 12'h343, 3'd4, 32'h0000_AAAA, 1'b1, 32'h0,         1'b1}, // R11 R4
    {8'd11, 12'h343, 3'd2, 32'h0,         1'b0, 32'h0000_000B, 1'b0}, // R11
    {8'd11, 12'h300, 3'd2, 32'h0,         1'b0, 32'h0000_1880, 1'b0}, // R11
    {8'd13, 12'hB00, 3'd2, 32'h0,         1'b0, EXTV,          1'b0}  // R13
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [11:0] a, input logic [2:0] o, input logic [31:0] s, input logic w);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_op = o; req_src = s; req_wen = w;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 R2: idle after reset
    check("R1 rsp_valid after reset", {31'b0, rsp_valid}, 32'd0);
    check("R2 req_ready after reset", {31'b0, req_ready}, 32'd1);

    for (int i = 0; i < NV; i++) begin
      logic [88:0] v;
      string tag;
      v = VEC[i];
      send(v[80:69], v[68:66], v[65:34], v[33]);
      tag = $sformatf("R%0d row %0d", v[88:81], i);
      check({tag, " valid"},   {31'b0, rsp_valid},   32'd1);
      check({tag, " rdata"},   rsp_rdata,            v[32:1]);
      check({tag, " illegal"}, {31'b0, rsp_illegal}, {31'b0, v[0]});
      check({tag, " cause R10"}, {28'b0, rsp_cause}, v[0] ? 32'd2 : 32'd0);
    end

    // R13: write strobe to the neighbour in the accept cycle
    @(negedge clk);
    req_valid = 1'b1; req_addr = 12'hB00; req_op = 3'd2; req_src = 32'h0000_0099; req_wen = 1'b1;
    #1;
    check("R13 ext_we", {31'b0, ext_we}, 32'd1);
    check("R13 ext_wdata", ext_wdata, EXTV | 32'h99);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R13 ext rdata", rsp_rdata, EXTV);
    // R13: no strobe without write intent
    req_valid = 1'b1; req_wen = 1'b0;
    #1;
    check("R13 ext_we no intent", {31'b0, ext_we}, 32'd0);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;

    // R2: back-pressure on the answer channel
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_addr = 12'hF11; req_op = 3'd2; req_src = 32'h0; req_wen = 1'b0;
    @(posedge clk);
    @(negedge clk);
    req_addr = 12'hF12;
    check("R2 stalled valid", {31'b0, rsp_valid}, 32'd1);
    check("R2 ready low when stalled", {31'b0, req_ready}, 32'd0);
    @(posedge clk);
    @(negedge clk);
    check("R2 held rdata", rsp_rdata, VEND);
    rsp_ready = 1'b1;
    #1;
    check("R2 ready on drain", {31'b0, req_ready}, 32'd1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R2 next answer", rsp_rdata, ARCH);
    @(posedge clk);
    @(negedge clk);
    check("R2 drained", {31'b0, rsp_valid}, 32'd0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule